// File: doc/BRIEF.md
# Vector-Length-Scaled Line Prefetcher

This block is a fill controller placed next to a direct-mapped data cache that serves a vector memory unit. When a vector load misses, the controller first requests the missing line from the memory side. It then walks forward through the following line addresses and requests enough of them to cover a multiple of the missing instruction's vector length. The later element groups of the same streaming operation then find their data already resident.

The prefetch depth is derived from the vector length, the element size and a build-time multiplier. It is rounded up to whole lines and bounded in three ways: by a capacity-derived cap, by the last line of the address space, and by cancellation when a newer miss arrives. Before each candidate line is requested, the controller probes the cache's tag check. A line that is already resident is stepped over without a fill. One fill is outstanding at a time, and a fill-done pulse from the memory side releases the controller. Three event counters expose demand fills, prefetch fills and hits on prefetched lines.

Top module: `vl_prefetch`

## Requirements
- R1: An accepted miss (miss_valid high while miss_ready is high) produces, on the next cycle, a one-cycle fill request for the missed line (address right-shifted by log2 of the line size) with fill_is_pf low.
- R2: The number of lines considered for prefetch after a miss is the smallest of three values. The first is ceil(PF_MULT × vl × ELEM_BYTES / LINE_BYTES). The second is the cap CACHE_BYTES / (MVL × LINE_BYTES) − 1, which is 3 lines with the defaults. The third is the count of lines above the missed line.
- R3: Prefetch fill requests carry fill_is_pf high and use ascending consecutive line numbers starting at the missed line plus one. Each is issued only after the previous fill's done pulse.
- R4: A candidate line for which probe_present is high while probe_line names it is not requested. It still counts against the prefetch depth.
- R5: A miss accepted while prefetch candidates remain discards every remaining candidate of the earlier stream. The new miss's demand fill is issued instead.
- R6: No prefetch request names a line beyond the last line of the address space, and none wraps to line 0.
- R7: miss_ready is low from a fill request until the cycle after its fill_done. No second fill request is made while one is outstanding.
- R8: cnt_demand counts demand fill requests, cnt_pf counts prefetch fill requests, and cnt_pf_hit counts cycles with pf_hit high. None of them decreases.
- R9: After reset, miss_ready is high, fill_valid is low and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Vector load miss presented |
| miss_addr | input | AW | Byte address of the missing access |
| miss_vl | input | clog2(MVL+1) | Vector length of the missing instruction, in elements |
| miss_ready | output | 1 | Controller can accept a miss |
| probe_line | output | AW−log2(LINE_BYTES) | Line currently being tag-checked |
| probe_present | input | 1 | Cache reports probe_line resident |
| fill_valid | output | 1 | One-cycle fill request |
| fill_line | output | AW−log2(LINE_BYTES) | Line number to fill |
| fill_is_pf | output | 1 | Request is a prefetch, not a demand fill |
| fill_done | input | 1 | Memory side finished the outstanding fill |
| pf_hit | input | 1 | Cache hit on a line brought in by prefetch |
| cnt_demand | output | CW | Demand fill count |
| cnt_pf | output | CW | Prefetch fill count |
| cnt_pf_hit | output | CW | Prefetched-line hit count |

## Verification
The bench goes after the depth rounding and the capacity cap, where short vectors need one line and long vectors saturate at the cap. A design that truncated instead of rounding up would leave the tail of a stream unfetched, and one without the cap would flood the cache. Misses in the last lines of the address space are aimed at the top-of-space bound; a controller without it would wrap around and fetch line 0. A pre-marked resident line inside a stream checks that the skip still consumes depth, so that the stream neither stalls on a redundant fill nor runs one line too far. A miss placed between two prefetches checks cancellation; a controller that kept the old stream would interleave stale fills ahead of the new demand.

// File: rtl/vlpf_pkg.sv
package vlpf_pkg;

   typedef enum logic {
      ST_RUN  = 1'b0,
      ST_WAIT = 1'b1
   } vlpf_state_e;

   function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/vlpf_depth.sv
module vlpf_depth #(
   parameter int AW          = 16,
   parameter int LINE_BYTES  = 64,
   parameter int ELEM_BYTES  = 4,
   parameter int MVL         = 16,
   parameter int PF_MULT     = 8,
   parameter int CACHE_BYTES = 4096,
   parameter int LOFF        = $clog2(LINE_BYTES),
   parameter int LIW         = AW - LOFF,
   parameter int VLW         = $clog2(MVL + 1)
) (
   input  logic [LIW-1:0] base_line,
   input  logic [VLW-1:0] vl,
   output logic [LIW-1:0] depth
);
   import vlpf_pkg::*;

   localparam int unsigned CAP      = CACHE_BYTES / (MVL * LINE_BYTES) - 1;
   localparam int unsigned RAW_MAX  = (PF_MULT * MVL * ELEM_BYTES + LINE_BYTES - 1) / LINE_BYTES;
   localparam logic [LIW-1:0] LMAX  = '1;

   logic [31:0]     raw_bytes;
   logic [31:0]     raw_lines;
   int unsigned     capped;
   logic [LIW-1:0]  avail;

   assign raw_bytes = 32'(PF_MULT * ELEM_BYTES) * 32'(vl);
   assign raw_lines = (raw_bytes + 32'(LINE_BYTES - 1)) >> LOFF;
   assign avail     = LMAX - base_line;

   generate
      if (RAW_MAX <= CAP) begin : g_uncapped
         assign capped = raw_lines;
      end else begin : g_capped
         assign capped = min_u(raw_lines, CAP);
      end
   endgenerate

   assign depth = LIW'(min_u(capped, 32'(avail)));
endmodule

// File: rtl/vlpf_seq.sv
module vlpf_seq #(
   parameter int LIW = 10,
   parameter int CAP = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           miss_valid,
   input  logic [LIW-1:0] miss_line,
   input  logic [LIW-1:0] depth,
   output logic           miss_ready,
   output logic [LIW-1:0] probe_line,
   input  logic           probe_present,
   output logic           fill_valid,
   output logic [LIW-1:0] fill_line,
   output logic           fill_is_pf,
   input  logic           fill_done,
   output logic           dem_pulse,
   output logic           pf_pulse
);
   import vlpf_pkg::*;

   vlpf_state_e    st;
   logic [LIW-1:0] rem;
   logic [LIW-1:0] nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_RUN;
         rem        <= '0;
         nxt        <= '0;
         fill_valid <= 1'b0;
         fill_line  <= '0;
         fill_is_pf <= 1'b0;
      end else begin
         fill_valid <= 1'b0;
         case (st)
            ST_RUN: begin
               if (miss_valid) begin
                  fill_valid <= 1'b1;
                  fill_line  <= miss_line;
                  fill_is_pf <= 1'b0;
                  nxt        <= miss_line + 1'b1;
                  rem        <= depth;
                  st         <= ST_WAIT;
               end else if (rem != '0) begin
                  nxt <= nxt + 1'b1;
                  rem <= rem - 1'b1;
                  if (!probe_present) begin
                     fill_valid <= 1'b1;
                     fill_line  <= nxt;
                     fill_is_pf <= 1'b1;
                     st         <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: begin
               if (fill_done) st <= ST_RUN;
            end
            default: st <= ST_RUN;
         endcase
      end
   end

   assign miss_ready = (st == ST_RUN);
   assign probe_line = nxt;
   assign dem_pulse  = fill_valid && !fill_is_pf;
   assign pf_pulse   = fill_valid && fill_is_pf;

   AST_DEMAND_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready) |=> (fill_valid && !fill_is_pf && fill_line == $past(miss_line))); // R1
   AST_REM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      rem <= LIW'(CAP)); // R2
   AST_PF_ABOVE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && fill_is_pf) |-> (fill_line != '0)); // R6
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> !miss_ready); // R7
   AST_NO_FILL_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      !miss_ready |=> !fill_valid); // R7
endmodule

// File: rtl/vlpf_stats.sv
module vlpf_stats #(
   parameter int N  = 3,
   parameter int CW = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N-1:0]        ev,
   output logic [N-1:0][CW-1:0] cnt
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_cnt
         always_ff @(posedge clk) begin
            if (!rst_n)     cnt[i] <= '0;
            else if (ev[i]) cnt[i] <= cnt[i] + 1'b1;
         end
         AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[i] >= $past(cnt[i])); // R8
      end
   endgenerate
endmodule

// File: rtl/vl_prefetch.sv
module vl_prefetch #(
   parameter int AW          = 16,
   parameter int LINE_BYTES  = 64,
   parameter int ELEM_BYTES  = 4,
   parameter int MVL         = 16,
   parameter int PF_MULT     = 8,
   parameter int CACHE_BYTES = 4096,
   parameter int CW          = 16,
   localparam int LOFF       = $clog2(LINE_BYTES),
   localparam int LIW        = AW - LOFF,
   localparam int VLW        = $clog2(MVL + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           miss_valid,
   input  logic [AW-1:0]  miss_addr,
   input  logic [VLW-1:0] miss_vl,
   output logic           miss_ready,
   output logic [LIW-1:0] probe_line,
   input  logic           probe_present,
   output logic           fill_valid,
   output logic [LIW-1:0] fill_line,
   output logic           fill_is_pf,
   input  logic           fill_done,
   input  logic           pf_hit,
   output logic [CW-1:0]  cnt_demand,
   output logic [CW-1:0]  cnt_pf,
   output logic [CW-1:0]  cnt_pf_hit
);
   localparam int CAP = CACHE_BYTES / (MVL * LINE_BYTES) - 1;

   generate
      if ((1 << LOFF) != LINE_BYTES || LINE_BYTES % ELEM_BYTES != 0) begin : g_bad_line
         $error("line size must be a power of two and hold whole elements");
      end
      if (CAP < 1) begin : g_bad_cap
         $error("cache too small for any prefetch at this vector length");
      end
      if (PF_MULT < 1 || LIW < 2) begin : g_bad_misc
         $error("multiplier or address width out of range");
      end
   endgenerate

   logic [LIW-1:0]        miss_line;
   logic [LIW-1:0]        depth;
   logic                  dem_pulse;
   logic                  pf_pulse;
   logic [2:0][CW-1:0]    cnts;

   assign miss_line = miss_addr[AW-1:LOFF];

   vlpf_depth #(
      .AW(AW), .LINE_BYTES(LINE_BYTES), .ELEM_BYTES(ELEM_BYTES),
      .MVL(MVL), .PF_MULT(PF_MULT), .CACHE_BYTES(CACHE_BYTES)
   ) u_depth (
      .base_line(miss_line),
      .vl       (miss_vl),
      .depth    (depth)
   );

   vlpf_seq #(.LIW(LIW), .CAP(CAP)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .miss_valid   (miss_valid),
      .miss_line    (miss_line),
      .depth        (depth),
      .miss_ready   (miss_ready),
      .probe_line   (probe_line),
      .probe_present(probe_present),
      .fill_valid   (fill_valid),
      .fill_line    (fill_line),
      .fill_is_pf   (fill_is_pf),
      .fill_done    (fill_done),
      .dem_pulse    (dem_pulse),
      .pf_pulse     (pf_pulse)
   );

   vlpf_stats #(.N(3), .CW(CW)) u_stats (
      .clk  (clk),
      .rst_n(rst_n),
      .ev   ({pf_hit, pf_pulse, dem_pulse}),
      .cnt  (cnts)
   );

   assign cnt_demand = cnts[0];
   assign cnt_pf     = cnts[1];
   assign cnt_pf_hit = cnts[2];
endmodule

// File: tb/sim_vl_prefetch.sv
module sim_vl_prefetch;
   localparam int AW = 16, LB = 64, LOFF = 6, LIW = 10, VLW = 5, CW = 16;
   localparam int CAPL = 3, LMAX = 1023, PEN = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic miss_valid = 1'b0;
   logic [AW-1:0] miss_addr = '0;
   logic [VLW-1:0] miss_vl = '0;
   logic miss_ready, fill_valid, fill_is_pf;
   logic [LIW-1:0] probe_line, fill_line;
   logic probe_present, fill_done, pf_hit = 1'b0;
   logic [CW-1:0] cnt_demand, cnt_pf, cnt_pf_hit;

   always #4 clk = ~clk;

   vl_prefetch u0 (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
      .miss_vl(miss_vl), .miss_ready(miss_ready), .probe_line(probe_line),
      .probe_present(probe_present), .fill_valid(fill_valid), .fill_line(fill_line),
      .fill_is_pf(fill_is_pf), .fill_done(fill_done), .pf_hit(pf_hit),
      .cnt_demand(cnt_demand), .cnt_pf(cnt_pf), .cnt_pf_hit(cnt_pf_hit));

   // cache presence model and fixed-latency memory
   logic present [0:LMAX];
   logic forced  [0:LMAX];
   logic [4:0] cd;
   logic [LIW-1:0] ln;
   int done_cnt;
   logic [LIW-1:0] lg_line [0:511];
   logic lg_pf [0:511];
   int lg_n;

   assign probe_present = present[probe_line] | forced[probe_line];

   always @(posedge clk) begin
      if (!rst_n) begin
         cd <= '0; fill_done <= 1'b0; done_cnt <= 0; lg_n <= 0; ln <= '0;
         for (int i = 0; i <= LMAX; i++) present[i] <= 1'b0;
      end else begin
         fill_done <= 1'b0;
         if (fill_done) done_cnt <= done_cnt + 1;
         if (fill_valid) begin
            cd <= 5'(PEN); ln <= fill_line;
            lg_line[lg_n] <= fill_line; lg_pf[lg_n] <= fill_is_pf; lg_n <= lg_n + 1;
         end else if (cd != 0) begin
            cd <= cd - 1'b1;
            if (cd == 1) begin fill_done <= 1'b1; present[ln] <= 1'b1; end
         end
      end
   end

   int total = 0, bad = 0, misses = 0, pfs = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_depth(input int base, input int vl);
      int d = (8 * vl * 4 + LB - 1) / LB;
      if (d > CAPL) d = CAPL;
      if (d > LMAX - base) d = LMAX - base;
      return d;
   endfunction

   // one miss, let it finish, compare logged fills with the model
   task automatic do_miss(input int line, input int vl, input string req);
      int exp_l [0:7];
      int n = 0;
      int st;
      bit ok;
      int d = exp_depth(line, vl);
      for (int i = 1; i <= d; i++)
         if (!(present[line + i] | forced[line + i])) begin exp_l[n] = line + i; n++; end
      @(negedge clk);
      while (!miss_ready) @(negedge clk);
      st = lg_n;
      miss_valid = 1'b1; miss_addr = AW'(line << LOFF) | AW'(vl); miss_vl = VLW'(vl);
      @(negedge clk);
      miss_valid = 1'b0;
      repeat (80) @(negedge clk);
      misses++; pfs += n;
      chk(lg_n - st == n + 1, {req, " fill count"}, lg_n - st, n + 1);
      ok = (lg_line[st] == LIW'(line)) && !lg_pf[st];
      chk(ok, "R1 demand line", int'(lg_line[st]), line);
      ok = 1'b1;
      for (int i = 0; i < n; i++)
         if (lg_line[st + 1 + i] != LIW'(exp_l[i]) || !lg_pf[st + 1 + i]) ok = 1'b0;
      chk(ok, {req, " prefetch sequence"}, lg_n - st, n + 1);
   endtask

   initial begin
      for (int i = 0; i <= LMAX; i++) forced[i] = 1'b0;
      forced[302] = 1'b1;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(miss_ready == 1'b1, "R9 ready", int'(miss_ready), 1);
      chk(fill_valid == 1'b0, "R9 fill idle", int'(fill_valid), 0);
      chk(cnt_demand == 0 && cnt_pf == 0 && cnt_pf_hit == 0, "R9 counters",
          int'(cnt_demand) + int'(cnt_pf) + int'(cnt_pf_hit), 0);
      // R2 rounding: short vectors
      do_miss(10, 1, "R2 vl1");
      do_miss(20, 3, "R2 vl3");
      // R2 cap at long vectors, R3 ascending
      do_miss(40, 16, "R2 cap");
      // R4 resident line skipped
      do_miss(300, 16, "R4 skip");
      // R6 near the top of the address space
      do_miss(1022, 16, "R6 top-1");
      do_miss(1023, 16, "R6 top");
      // R5 cancellation between prefetches
      begin
         int st;
         int d0;
         @(negedge clk);
         while (!miss_ready) @(negedge clk);
         st = lg_n; d0 = done_cnt;
         miss_valid = 1'b1; miss_addr = AW'(100 << LOFF); miss_vl = VLW'(16);
         @(negedge clk);
         miss_valid = 1'b0;
         while (!(done_cnt == d0 + 2 && miss_ready)) @(negedge clk);
         miss_valid = 1'b1; miss_addr = AW'(200 << LOFF); miss_vl = VLW'(16);
         @(negedge clk);
         miss_valid = 1'b0;
         repeat (80) @(negedge clk);
         misses += 2; pfs += 4;
         chk(lg_n - st == 6, "R5 fill count", lg_n - st, 6);
         chk(lg_line[st + 1] == 10'd101 && lg_line[st + 2] == 10'd200 && !lg_pf[st + 2],
             "R5 new demand after one prefetch", int'(lg_line[st + 2]), 200);
         chk(lg_line[st + 5] == 10'd203, "R5 new stream tail", int'(lg_line[st + 5]), 203);
      end
      // R7 ready low while waiting
      begin
         @(negedge clk);
         miss_valid = 1'b1; miss_addr = AW'(500 << LOFF); miss_vl = VLW'(1);
         @(negedge clk);
         miss_valid = 1'b0;
         chk(fill_valid == 1'b1 && miss_ready == 1'b0, "R7 busy on fill",
             int'(miss_ready), 0);
         repeat (5) @(negedge clk);
         chk(miss_ready == 1'b0 && fill_valid == 1'b0, "R7 still waiting",
             int'(miss_ready), 0);
         repeat (80) @(negedge clk);
         misses++; pfs++;
      end
      // random streams
      for (int k = 0; k < 20; k++)
         do_miss(int'($urandom_range(0, LMAX)), int'($urandom_range(1, 16)), "R2 random");
      // R8 counters
      repeat (3) begin
         pf_hit = 1'b1; @(negedge clk); pf_hit = 1'b0; @(negedge clk);
      end
      chk(cnt_pf_hit == 16'd3, "R8 hit count", int'(cnt_pf_hit), 3);
      chk(int'(cnt_demand) == misses, "R8 demand count", int'(cnt_demand), misses);
      chk(int'(cnt_pf) == pfs, "R8 prefetch count", int'(cnt_pf), pfs);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule